// File: doc/BRIEF.md
# Indexed Shadow-RAM Configuration and Routing Unit

This block is the configuration unit of a legacy PC chipset. Software reaches it through two I/O ports: one port loads an 8-bit index, the other reads or writes the byte at that index in a 256-entry register file. Three of those registers set the shadow attributes of the upper memory area, from C0000h up to FFFFFh. Each attribute says whether a read or a write in that area is served by on-board shadow DRAM or is passed to the expansion bus.

For every host memory access, the block looks at the 20-bit address and the direction strobe. It raises `route_internal_rd` or `route_internal_wr` when the access stays on the board. The decode is combinational from the address and the register file. Two smaller side functions complete the unit. One register bit drives an external-cache enable. Any write to the timing register sends a one-cycle reload pulse to the wait-state logic downstream.

Top module: `shadow_cfg_top`

## Requirements
- R1: An I/O write to port 8022h loads `io_wdata` into the index register. The new index is in use from the next clock edge.
- R2: An I/O write to port 8024h stores `io_wdata` into the register at the current index. An I/O read of port 8024h returns that register on `io_rdata` in the same cycle.
- R3: `io_rdata` is FFh whenever `io_rd` is low or `io_addr` is not 8024h. I/O writes to any port other than 8022h and 8024h change no state.
- R4: Host addresses below C0000h are always internal. A read raises `route_internal_rd` and a write (`mem_wr`=1) raises `route_internal_wr`.
- R5: The 16 KB segments from C0000h to DFFFFh are controlled by two registers. Register CDh covers C0000h, C4000h, C8000h and CC000h with bit pairs 7:6, 5:4, 3:2 and 1:0. Register CEh covers D0000h, D4000h, D8000h and DC000h with the same bit pairs.
- R6: Register CCh controls the two 64 KB segments. Bits 5:4 govern E0000h–EFFFFh and bits 7:6 govern F0000h–FFFFFh.
- R7: In every bit pair, the upper bit enables internal writes and the lower bit enables internal reads. A clear bit sends that access type to the external bus, with both route outputs low. `route_internal_rd` is only high when `mem_wr`=0, and `route_internal_wr` is only high when `mem_wr`=1.
- R8: Synchronous active-low reset clears the index and every register to 00h. After reset, all of C0000h–FFFFFh is external for both reads and writes, and both side outputs are low.
- R9: `ext_cache_en` equals bit 0 of register D1h.
- R10: A data-port write while the index is D0h raises `waitstate_update` for exactly the next cycle. No other access raises it.
- R11: A data-port write to a shadow register changes the route outputs from the following clock edge. In the cycle of the write, the routes still follow the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, FFh when not selected |
| mem_addr | input | 20 | Host memory address |
| mem_wr | input | 1 | Host access direction, 1 = write |
| route_internal_rd | output | 1 | Read served by shadow DRAM |
| route_internal_wr | output | 1 | Write served by shadow DRAM |
| ext_cache_en | output | 1 | External cache enable |
| waitstate_update | output | 1 | One-cycle reload pulse for wait-state logic |

## Verification
The route outputs and `io_rdata` are combinational, so they are due in the same cycle as the address that selects them. A register or index write reaches those outputs one clock edge later. `waitstate_update` and `ext_cache_en` also follow one edge after the write that causes them.

The bench drives each stimulus just after the falling edge and samples every output one nanosecond later, against a behavioural model. It updates that model only at the rising edge, so the edge that separates old and new values lines up between model and design. The routing case of R11 is checked in both the write cycle and the cycle that follows it.

// File: rtl/shadow_cfg_pkg.sv
`timescale 1ns/1ps
// Package: shadow_cfg_pkg
// Shared constants and types of the shadow configuration unit. Register
// indices and bit positions live here because the router and the top both
// decode them. Assumes a byte-wide register file with an 8-bit index.
package shadow_cfg_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 8;

    typedef logic [DATA_W-1:0] cfg_byte_t;
    typedef logic [IDX_W-1:0]  cfg_idx_t;

    // Register indices whose contents the hardware decodes.
    localparam cfg_idx_t REG_SHADOW_EF = 8'hCC;
    localparam cfg_idx_t REG_SHADOW_C  = 8'hCD;
    localparam cfg_idx_t REG_SHADOW_D  = 8'hCE;
    localparam cfg_idx_t REG_TIMING    = 8'hD0;
    localparam cfg_idx_t REG_CACHE     = 8'hD1;

    // Bit positions inside the 64 KB segment register.
    localparam int EF_E_RD_BIT = 4;
    localparam int EF_E_WR_BIT = 5;
    localparam int EF_F_RD_BIT = 6;
    localparam int EF_F_WR_BIT = 7;

    // Bit of the cache register that drives the enable output.
    localparam int CACHE_EN_BIT = 0;

    // Kind of I/O port selected by the current access.
    typedef enum logic [1:0] {
        IO_SEL_NONE  = 2'd0,
        IO_SEL_INDEX = 2'd1,
        IO_SEL_DATA  = 2'd2
    } io_sel_e;

endpackage

// File: rtl/cfg_io_decode.sv
`timescale 1ns/1ps
// Module: cfg_io_decode
// Decodes the I/O port pair and holds the index register. An index-port
// write loads the index. A data-port access produces the register file write
// enable or read select. Assumes io_wr and io_rd are never both high, and
// that IDX_W is not larger than DATA_W.
module cfg_io_decode
    import shadow_cfg_pkg::*;
#(
    parameter int               IO_W      = 16,
    parameter logic [IO_W-1:0]  IDX_PORT  = 16'h8022,
    parameter logic [IO_W-1:0]  DATA_PORT = 16'h8024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IO_W-1:0] io_addr,
    input  logic            io_wr,
    input  logic            io_rd,
    input  cfg_byte_t       io_wdata,
    output cfg_idx_t        idx_q,
    output logic            data_we,
    output logic            data_re
);

    io_sel_e sel;

    // Classify the port address of the current access.
    always_comb begin
        if (io_addr == IDX_PORT)       sel = IO_SEL_INDEX;
        else if (io_addr == DATA_PORT) sel = IO_SEL_DATA;
        else                           sel = IO_SEL_NONE;
    end

    // Strobes toward the register file.
    always_comb begin
        data_we = io_wr && (sel == IO_SEL_DATA);
        data_re = io_rd && (sel == IO_SEL_DATA);
    end

    // Index register: cleared by reset, loaded by an index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n)                               idx_q <= '0;
        else if (io_wr && sel == IO_SEL_INDEX)    idx_q <= io_wdata[IDX_W-1:0];
    end

    p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == IDX_PORT) |=> (idx_q == $past(io_wdata[IDX_W-1:0])));

    p_index_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == IDX_PORT) |=> $stable(idx_q));

endmodule

// File: rtl/cfg_regfile.sv
`timescale 1ns/1ps
// Module: cfg_regfile
// Byte-wide register file with one synchronous write port and one
// combinational read port. A few fixed entries are exposed as taps for the
// decode logic. Reset clears every entry. Assumes the tap indices lie
// inside the file.
module cfg_regfile
    import shadow_cfg_pkg::*;
#(
    parameter cfg_idx_t TAP_EF    = REG_SHADOW_EF,
    parameter cfg_idx_t TAP_C     = REG_SHADOW_C,
    parameter cfg_idx_t TAP_D     = REG_SHADOW_D,
    parameter cfg_idx_t TAP_CACHE = REG_CACHE
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  cfg_idx_t  widx,
    input  cfg_byte_t wdata,
    input  cfg_idx_t  ridx,
    output cfg_byte_t rdata,
    output cfg_byte_t tap_ef,
    output cfg_byte_t tap_c,
    output cfg_byte_t tap_d,
    output cfg_byte_t tap_cache
);

    localparam int DEPTH = 1 << IDX_W;

    cfg_byte_t mem [DEPTH];

    // Storage: synchronous clear on reset, one write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Read port and fixed taps.
    always_comb begin
        rdata     = mem[ridx];
        tap_ef    = mem[TAP_EF];
        tap_c     = mem[TAP_C];
        tap_d     = mem[TAP_D];
        tap_cache = mem[TAP_CACHE];
    end

    p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/shadow_router.sv
`timescale 1ns/1ps
// Module: shadow_router
// Combinational region decode of the host address. Below the upper area,
// every access stays internal. From C0000h to DFFFFh, each 16 KB segment
// uses one bit pair, with the first segment of a bank in the top pair. The
// E and F segments are 64 KB each. In every pair the upper bit is write and
// the lower bit is read. Assumes a 20-bit host address.
module shadow_router
    import shadow_cfg_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_wr,
    input  cfg_byte_t         reg_ef,
    input  cfg_byte_t         reg_c,
    input  cfg_byte_t         reg_d,
    output logic              route_rd,
    output logic              route_wr
);

    localparam int SEG_PER_BANK = DATA_W / 2;     // 16 KB segments per register
    localparam int SEG_CNT      = 2 * SEG_PER_BANK;
    localparam int SEG_SEL_W    = $clog2(SEG_CNT);

    logic [SEG_CNT-1:0]   seg_rd_en;
    logic [SEG_CNT-1:0]   seg_wr_en;
    logic [SEG_SEL_W-1:0] seg_sel;
    logic                 in_upper;
    logic                 int_rd;
    logic                 int_wr;

    // Unpack the two 16 KB banks: segment g of a bank sits in pair (n-1-g).
    for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg
        localparam int PAIR = SEG_PER_BANK - 1 - (g % SEG_PER_BANK);
        if (g < SEG_PER_BANK) begin : g_bank_c
            assign seg_rd_en[g] = reg_c[2*PAIR];
            assign seg_wr_en[g] = reg_c[2*PAIR+1];
        end else begin : g_bank_d
            assign seg_rd_en[g] = reg_d[2*PAIR];
            assign seg_wr_en[g] = reg_d[2*PAIR+1];
        end
    end

    // Locate the address: upper area test and 16 KB segment number.
    always_comb begin
        in_upper = (mem_addr[19:18] == 2'b11);
        seg_sel  = mem_addr[16:14];
    end

    // Pick the internal enables for the segment that holds the address.
    always_comb begin
        if (!in_upper) begin
            int_rd = 1'b1;
            int_wr = 1'b1;
        end else if (!mem_addr[17]) begin
            int_rd = seg_rd_en[seg_sel];
            int_wr = seg_wr_en[seg_sel];
        end else if (!mem_addr[16]) begin
            int_rd = reg_ef[EF_E_RD_BIT];
            int_wr = reg_ef[EF_E_WR_BIT];
        end else begin
            int_rd = reg_ef[EF_F_RD_BIT];
            int_wr = reg_ef[EF_F_WR_BIT];
        end
    end

    // Qualify with the direction of the access.
    always_comb begin
        route_rd = !mem_wr && int_rd;
        route_wr =  mem_wr && int_wr;
    end

endmodule

// File: rtl/shadow_cfg_top.sv
`timescale 1ns/1ps
// Module: shadow_cfg_top
// Shadow-RAM configuration unit: the I/O decode, the register file and the
// region router, plus the cache-enable output and the wait-state reload
// pulse. Assumes one I/O strobe per cycle and a host address that is stable
// while the route outputs are in use.
module shadow_cfg_top
    import shadow_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic [19:0] mem_addr,
    input  logic        mem_wr,
    output logic        route_internal_rd,
    output logic        route_internal_wr,
    output logic        ext_cache_en,
    output logic        waitstate_update
);

    localparam logic [15:0] IDX_PORT  = 16'h8022;
    localparam logic [15:0] DATA_PORT = 16'h8024;

    cfg_idx_t  idx_q;
    logic      data_we;
    logic      data_re;
    cfg_byte_t rf_rdata;
    cfg_byte_t tap_ef;
    cfg_byte_t tap_c;
    cfg_byte_t tap_d;
    cfg_byte_t tap_cache;
    logic      ws_q;

    cfg_io_decode #(
        .IO_W      (16),
        .IDX_PORT  (IDX_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .idx_q    (idx_q),
        .data_we  (data_we),
        .data_re  (data_re)
    );

    cfg_regfile #(
        .TAP_EF    (REG_SHADOW_EF),
        .TAP_C     (REG_SHADOW_C),
        .TAP_D     (REG_SHADOW_D),
        .TAP_CACHE (REG_CACHE)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (data_we),
        .widx      (idx_q),
        .wdata     (io_wdata),
        .ridx      (idx_q),
        .rdata     (rf_rdata),
        .tap_ef    (tap_ef),
        .tap_c     (tap_c),
        .tap_d     (tap_d),
        .tap_cache (tap_cache)
    );

    shadow_router #(
        .ADDR_W (20)
    ) u_route (
        .mem_addr (mem_addr),
        .mem_wr   (mem_wr),
        .reg_ef   (tap_ef),
        .reg_c    (tap_c),
        .reg_d    (tap_d),
        .route_rd (route_internal_rd),
        .route_wr (route_internal_wr)
    );

    // Read mux: the selected register on a data-port read, all ones otherwise.
    always_comb begin
        io_rdata = data_re ? rf_rdata : 8'hFF;
    end

    // Reload pulse: one cycle after a data-port write to the timing register.
    always_ff @(posedge clk) begin
        if (!rst_n) ws_q <= 1'b0;
        else        ws_q <= data_we && (idx_q == REG_TIMING);
    end

    // Side outputs.
    always_comb begin
        waitstate_update = ws_q;
        ext_cache_en     = tap_cache[CACHE_EN_BIT];
    end

    p_low_internal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr < 20'hC0000) |-> (mem_wr ? route_internal_wr : route_internal_rd));

    p_dir_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(route_internal_rd && route_internal_wr));

    p_reset_external_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && mem_addr >= 20'hC0000) |-> (!route_internal_rd && !route_internal_wr));

    p_cache_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == DATA_PORT && idx_q == REG_CACHE) |=> (ext_cache_en == $past(io_wdata[0])));

    p_ws_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == DATA_PORT && idx_q == REG_TIMING) |=> waitstate_update);

    p_ws_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        waitstate_update |-> $past(io_wr && io_addr == DATA_PORT && idx_q == REG_TIMING));

    p_unselected_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_addr == DATA_PORT) |-> (io_rdata == 8'hFF));

endmodule

// File: tb/tb_shadow_cfg_top.sv
`timescale 1ns/1ps
// Bench for shadow_cfg_top: a behavioural model that is compared on every
// cycle, one nanosecond after the falling edge.
module tb_shadow_cfg_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] io_addr;
    logic        io_wr;
    logic        io_rd;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic [19:0] mem_addr;
    logic        mem_wr;
    logic        route_rd;
    logic        route_wr;
    logic        cache_en;
    logic        ws;

    always #2 clk = ~clk;   // 250 MHz

    shadow_cfg_top dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .io_addr           (io_addr),
        .io_wr             (io_wr),
        .io_rd             (io_rd),
        .io_wdata          (io_wdata),
        .io_rdata          (io_rdata),
        .mem_addr          (mem_addr),
        .mem_wr            (mem_wr),
        .route_internal_rd (route_rd),
        .route_internal_wr (route_wr),
        .ext_cache_en      (cache_en),
        .waitstate_update  (ws)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Behavioural model state.
    logic [7:0] m_regs [256];
    logic [7:0] m_idx;
    logic       m_ws;

    // Expected internal enables for an address, taken from the register model.
    function automatic void m_route(input logic [19:0] a, output logic rd_i, output logic wr_i);
        int         seg;
        int         sh;
        logic [7:0] r;
        if (a < 20'hC0000) begin
            rd_i = 1'b1; wr_i = 1'b1;
        end else if (a >= 20'hF0000) begin
            rd_i = m_regs[8'hCC][6]; wr_i = m_regs[8'hCC][7];
        end else if (a >= 20'hE0000) begin
            rd_i = m_regs[8'hCC][4]; wr_i = m_regs[8'hCC][5];
        end else begin
            seg  = int'((a - 20'hC0000) / 20'h4000);
            r    = (seg < 4) ? m_regs[8'hCD] : m_regs[8'hCE];
            sh   = 6 - 2 * (seg % 4);
            rd_i = r[sh]; wr_i = r[sh+1];
        end
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string ctx);
        logic       erd;
        logic       ewr;
        logic [7:0] exp_rd;
        string      rtag;
        bit         sel;
        m_route(mem_addr, erd, ewr);
        sel    = io_rd && (io_addr == 16'h8024);
        exp_rd = sel ? m_regs[m_idx] : 8'hFF;
        chk(sel ? "R2" : "R3", {ctx, " io_rdata"}, io_rdata, exp_rd);
        rtag = (mem_addr < 20'hC0000) ? "R4" : ((mem_addr >= 20'hE0000) ? "R6" : "R5");
        chk(rtag, {ctx, " route_rd"}, {7'd0, route_rd}, {7'd0, !mem_wr && erd});
        chk(rtag, {ctx, " route_wr"}, {7'd0, route_wr}, {7'd0, mem_wr && ewr});
        chk("R9",  {ctx, " ext_cache_en"}, {7'd0, cache_en}, {7'd0, m_regs[8'hD1][0]});
        chk("R10", {ctx, " waitstate_update"}, {7'd0, ws}, {7'd0, m_ws});
    endtask

    // One cycle: check the current inputs, then advance the model at the edge.
    task automatic tick(input string ctx);
        #1;
        compare(ctx);
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_regs[i] = 8'h00;
            m_idx = 8'h00;
            m_ws  = 1'b0;
        end else begin
            m_ws = io_wr && (io_addr == 16'h8024) && (m_idx == 8'hD0);
            if (io_wr && io_addr == 16'h8022)      m_idx = io_wdata;
            else if (io_wr && io_addr == 16'h8024) m_regs[m_idx] = io_wdata;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        io_wr = 1'b0; io_rd = 1'b0; io_addr = 16'h0000; io_wdata = 8'h00;
    endtask

    task automatic set_index(input logic [7:0] r);
        io_addr = 16'h8022; io_wr = 1'b1; io_rd = 1'b0; io_wdata = r;
        tick("R1 index write");
        idle();
    endtask

    task automatic wr_reg(input logic [7:0] r, input logic [7:0] v);
        set_index(r);
        io_addr = 16'h8024; io_wr = 1'b1; io_wdata = v;
        tick("R2 data write / R11 old route");
        idle();
    endtask

    task automatic rd_reg(input logic [7:0] r, input string ctx);
        set_index(r);
        io_addr = 16'h8024; io_rd = 1'b1;
        tick(ctx);
        idle();
    endtask

    task automatic probe(input logic [19:0] a, input logic w, input string ctx);
        mem_addr = a; mem_wr = w;
        tick(ctx);
    endtask

    // Every 16 KB boundary of the upper area, both ends, both directions.
    task automatic sweep(input string ctx);
        for (int s = 0; s < 16; s++) begin
            for (int w = 0; w < 2; w++) begin
                probe(20'hC0000 + 20'(s) * 20'h4000, w[0], ctx);
                probe(20'hC3FFF + 20'(s) * 20'h4000, w[0], ctx);
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick("R8 in reset");
        tick("R8 in reset");
        rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) m_regs[i] = 8'h00;
        m_idx = 8'h00; m_ws = 1'b0;
        rst_n = 1'b0; idle(); mem_addr = 20'hC0000; mem_wr = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        do_reset();

        // R8: defaults after reset.
        rd_reg(8'hCC, "R8 default CC");
        rd_reg(8'hCD, "R8 default CD");
        rd_reg(8'hCE, "R8 default CE");
        rd_reg(8'hD1, "R8 default D1");
        sweep("R8 external after reset");

        // R4: low memory always internal.
        probe(20'h00000, 1'b0, "R4 low");
        probe(20'h00000, 1'b1, "R4 low");
        probe(20'h9FFFF, 1'b1, "R4 low");
        probe(20'hBFFFF, 1'b0, "R4 low edge");
        probe(20'hBFFFF, 1'b1, "R4 low edge");

        // R5, R6, R7: every single bit of each shadow register.
        for (int r = 0; r < 3; r++) begin
            for (int b = 0; b < 8; b++) begin
                wr_reg(8'hCC + 8'(r), 8'(1 << b));
                sweep("R5 R6 R7 single bit sweep");
            end
            wr_reg(8'hCC + 8'(r), 8'h00);
        end
        wr_reg(8'hCD, 8'hAA); wr_reg(8'hCE, 8'h55); wr_reg(8'hCC, 8'hF0);
        sweep("R7 polarity pattern");
        wr_reg(8'hCD, 8'hFF); wr_reg(8'hCE, 8'hFF); wr_reg(8'hCC, 8'h30);
        sweep("R6 E only");

        // R11: the routing change takes effect from the edge after the data write.
        wr_reg(8'hCD, 8'h00);
        mem_addr = 20'hC4000; mem_wr = 1'b0;
        set_index(8'hCD);
        io_addr = 16'h8024; io_wr = 1'b1; io_wdata = 8'h10;
        tick("R11 write cycle keeps old route");
        idle();
        tick("R11 new route next cycle");
        mem_wr = 1'b1;
        tick("R11 write dir still external");

        // R10: reload pulse only for a data write at index D0.
        wr_reg(8'hD0, 8'h07);
        tick("R10 pulse over");
        set_index(8'hD0);
        tick("R10 index write alone gives no pulse");
        io_addr = 16'h8024; io_wr = 1'b1; io_wdata = 8'h01;
        tick("R10 write");
        io_wdata = 8'h02;
        tick("R10 back to back");
        idle();
        tick("R10 after");
        wr_reg(8'hD2, 8'h01);
        tick("R10 other index no pulse");

        // R9: cache enable follows bit 0 of D1.
        wr_reg(8'hD1, 8'h01); tick("R9 set");
        wr_reg(8'hD1, 8'hFE); tick("R9 clear");
        wr_reg(8'hD1, 8'h03); tick("R9 set again");

        // R3: undecoded ports read FFh and ignore writes.
        set_index(8'hCD);
        io_rd = 1'b1;
        io_addr = 16'h8022; tick("R3 read index port");
        io_addr = 16'h8023; tick("R3 read 8023");
        io_addr = 16'h8025; tick("R3 read 8025");
        io_addr = 16'h0024; tick("R3 read 0024");
        io_rd = 1'b0; io_addr = 16'h8024; tick("R3 no strobe");
        idle();
        io_wr = 1'b1; io_addr = 16'h8023; io_wdata = 8'hEE; tick("R3 stray write");
        io_addr = 16'h8025; tick("R3 stray write");
        idle();
        io_addr = 16'h8024; io_rd = 1'b1; tick("R3 R1 index and CD unchanged");
        idle();

        // R1, R2: general register file storage.
        for (int i = 0; i < 256; i += 17) wr_reg(8'(i), 8'(i) ^ 8'h3C);
        for (int i = 0; i < 256; i += 17) rd_reg(8'(i), "R2 readback");

        // R8: a second reset returns everything to defaults.
        wr_reg(8'hCC, 8'hFF); wr_reg(8'hD1, 8'h01);
        do_reset();
        rd_reg(8'hCC, "R8 second reset CC");
        rd_reg(8'h11, "R8 second reset other");
        sweep("R8 external after second reset");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule